// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block is a clocked sequencer for an external asynchronous single-bit static RAM. The RAM has a 16-bit address, a separate data-in pin and data-out pin, and two active-low strobes: chip select and write strobe. On the user side, a valid/ready request carries an address, a write flag and one bit of write data. Each accepted request ends with a one-cycle `ack`. For a read, `rd_data` holds the sampled bit.

The RAM's timing minimums are given as nanosecond parameters together with the clock period. The block turns each of them into a whole number of cycles by rounding up, with a floor of one cycle. The controller then orders the strobes so that the address and data are stable around every strobe edge. When no access is running, the RAM is held in standby. After reset, and after each `retention_exit` pulse, the controller enforces a recovery wait of one read-cycle time before it accepts any request.

The state machine has six states:

- ST_RECOVER is the reset state. It returns to ST_IDLE when its timer expires, and it restarts its timer on a new `retention_exit` pulse.
- ST_IDLE goes to ST_RECOVER on `retention_exit`. On an accepted write it goes to ST_WR_SETUP; on an accepted read it goes to ST_RD_ACCESS.
- ST_WR_SETUP goes to ST_WR_PULSE after one cycle.
- ST_WR_PULSE goes to ST_WR_HOLD when the pulse timer expires.
- ST_WR_HOLD goes to ST_IDLE after one cycle.
- ST_RD_ACCESS goes to ST_IDLE when the access timer expires.

Top module: `sram_ctl`

## Requirements
- R1: Whenever no access is in progress (reset, recovery, idle), `mem_ce_n` and `mem_we_n` are both 1.
- R2: `req_ready` is 1 only in idle, with the cycle window of the previous access expired and `retention_exit` low. A request is taken on a cycle with `req_valid` and `req_ready` both 1.
- R3: A write drives address and data with both strobes high for one cycle. Then `mem_ce_n`=`mem_we_n`=0 for PULSE_CYC cycles, where PULSE_CYC = max(cycles(pulse width), cycles(data setup)). Then both strobes are high for one hold cycle. `ack` rises PULSE_CYC+3 cycles after the accepting cycle.
- R4: `mem_addr` stays constant while `mem_ce_n` is 0. `mem_din` and `mem_addr` stay constant while `mem_we_n` is 0 and in the hold cycle after it.
- R5: A read holds `mem_ce_n`=0 and `mem_we_n`=1 for AA_CYC cycles and samples `mem_dout` at the end of the last one. `ack` and the new `rd_data` appear AA_CYC+1 cycles after the accepting cycle. `rd_data` keeps its value through later writes.
- R6: `ack` is high for exactly one cycle per request.
- R7: The next access can be accepted no sooner than RC_CYC cycles after a read was accepted, and WC_CYC cycles after a write was accepted.
- R8: After reset, `req_ready` stays 0 for REC_CYC cycles, with the strobes high.
- R9: A `retention_exit` pulse seen in idle takes priority over a request in the same cycle. It holds `req_ready` at 0 for REC_CYC cycles after that cycle.
- R10: Each cycle count is ceil(ns / CLK_NS), with a minimum of 1.
- R11: `mem_we_n` is never 0 while `mem_ce_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retention_exit | input | 1 | Pulse: power restored after low-voltage retention |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Bit location |
| req_wdata | input | 1 | Bit to write |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 1 | Last bit read |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_din | output | 1 | Bit driven to RAM data input |
| mem_dout | input | 1 | Bit from RAM data output |

## Verification
The assertions check on every cycle the properties that hold for all traffic:

- the strobes are in standby while idle or recovering;
- the write strobe never falls outside chip select;
- address and data stay stable under the strobes;
- the write-strobe width equals PULSE_CYC;
- `ack` is a single-cycle pulse;
- the first cycle after acceptance is correct for each request kind.

Only the bench scenarios can show the rest:

- the data returned by a RAM model after mixed write/read patterns, at both ends of the address range;
- the end-to-end latencies and the spacing of back-to-back accesses;
- the recovery windows after reset and after `retention_exit`, including the priority of `retention_exit` over a request in the same cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_RECOVER,
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS
    } ctl_state_e;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int              WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);

    logic [WIDTH-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R7: an expired window stays expired until reloaded
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sram_ctl_capture.sv
module sram_ctl_capture #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    input  logic              take_rd,
    input  logic              mem_dout,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wdata_q,
    output logic              rd_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= 1'b0;
        end else if (take_req) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= 1'b0;
        else if (take_rd)
            rd_q <= mem_dout;
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int CLK_NS       = 10,
    parameter int T_RC_NS      = 12,
    parameter int T_WC_NS      = 12,
    parameter int T_WP_NS      = 10,
    parameter int T_DS_NS      = 7,
    parameter int T_AA_NS      = 12,
    parameter int T_RECOVER_NS = T_RC_NS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retention_exit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              ack,
    output logic              rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_din,
    input  logic              mem_dout
);

    localparam int RC_CYC    = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int WC_CYC    = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int WP_CYC    = ns_to_cycles(T_WP_NS, CLK_NS);
    localparam int DS_CYC    = ns_to_cycles(T_DS_NS, CLK_NS);
    localparam int AA_CYC    = ns_to_cycles(T_AA_NS, CLK_NS);
    localparam int REC_CYC   = ns_to_cycles(T_RECOVER_NS, CLK_NS);
    localparam int PULSE_CYC = max2(WP_CYC, DS_CYC);
    localparam int CNT_MAX   = max2(max2(max2(RC_CYC, WC_CYC), max2(PULSE_CYC, AA_CYC)), REC_CYC);
    localparam int TW        = $clog2(CNT_MAX + 1);

    ctl_state_e state, nxt;

    logic          accept;
    logic          phase_load, phase_zero;
    logic [TW-1:0] phase_val;
    logic          cyc_zero;
    logic [TW-1:0] cyc_val;
    logic          rd_take;
    logic          ce_n_q, we_n_q, ack_q;

    assign req_ready = (state == ST_IDLE) && cyc_zero && !retention_exit;
    assign accept    = req_valid && req_ready;
    assign cyc_val   = req_write ? TW'(WC_CYC - 1) : TW'(RC_CYC - 1);
    assign rd_take   = (state == ST_RD_ACCESS) && phase_zero;

    // Per-state duration timer (also covers the recovery wait).
    sram_ctl_timer #(.WIDTH(TW), .RST_VAL(TW'(REC_CYC - 1))) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .zero     (phase_zero)
    );

    // Access-start to next-access-start window.
    sram_ctl_timer #(.WIDTH(TW), .RST_VAL('0)) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cyc_val),
        .zero     (cyc_zero)
    );

    sram_ctl_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_req  (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .take_rd   (rd_take),
        .mem_dout  (mem_dout),
        .addr_q    (mem_addr),
        .wdata_q   (mem_din),
        .rd_q      (rd_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RECOVER;
        else
            state <= nxt;
    end

    // Next state and phase timer loads
    always_comb begin
        nxt        = state;
        phase_load = 1'b0;
        phase_val  = '0;
        unique case (state)
            ST_RECOVER: begin
                if (retention_exit) begin
                    phase_load = 1'b1;
                    phase_val  = TW'(REC_CYC - 1);
                end else if (phase_zero) begin
                    nxt = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (retention_exit) begin
                    nxt        = ST_RECOVER;
                    phase_load = 1'b1;
                    phase_val  = TW'(REC_CYC - 1);
                end else if (accept) begin
                    if (req_write) begin
                        nxt = ST_WR_SETUP;
                    end else begin
                        nxt        = ST_RD_ACCESS;
                        phase_load = 1'b1;
                        phase_val  = TW'(AA_CYC - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                nxt        = ST_WR_PULSE;
                phase_load = 1'b1;
                phase_val  = TW'(PULSE_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (phase_zero) nxt = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                nxt = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (phase_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Registered strobes and acknowledge, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
            we_n_q <= 1'b1;
            ack_q  <= 1'b0;
        end else begin
            ce_n_q <= !((nxt == ST_WR_PULSE) || (nxt == ST_RD_ACCESS));
            we_n_q <= !(nxt == ST_WR_PULSE);
            ack_q  <= (state == ST_WR_HOLD) || rd_take;
        end
    end

    assign mem_ce_n = ce_n_q;
    assign mem_we_n = we_n_q;
    assign ack      = ack_q;

    // Write strobe low-run counter, used only by the width check
    logic [TW-1:0] we_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            we_low_run <= '0;
        else if (!mem_we_n)
            we_low_run <= we_low_run + 1'b1;
        else
            we_low_run <= '0;
    end

    // R1
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_RECOVER) |-> (mem_ce_n && mem_we_n));

    // R11
    we_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R4
    addr_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R4
    din_under_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_din) && $stable(mem_addr)));

    // R3
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_run == TW'(PULSE_CYC)));

    // R3
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |=> (mem_ce_n && mem_we_n && mem_addr == $past(req_addr)));

    // R5
    rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write) |=> (!mem_ce_n && mem_we_n));

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

endmodule

// File: tb/sram_ctl_test.sv
module sram_ctl_test;

    localparam int CLK = 10;
    localparam int AW  = 16;

    localparam int P_RC = 45, P_WC = 12, P_WP = 25, P_DS = 7, P_AA = 12, P_REC = 45;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction

    // R10: bench derives its own cycle counts
    localparam int E_RC    = cyc(P_RC);
    localparam int E_AA    = cyc(P_AA);
    localparam int E_REC   = cyc(P_REC);
    localparam int E_PULSE = (cyc(P_WP) > cyc(P_DS)) ? cyc(P_WP) : cyc(P_DS);

    logic clk = 1'b0, rst_n = 1'b0, retention_exit = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready, ack, rd_data, mem_ce_n, mem_we_n, mem_din, mem_dout;
    logic [AW-1:0] mem_addr;

    always #(CLK/2) clk = ~clk;

    sram_ctl #(.ADDR_W(AW), .CLK_NS(CLK), .T_RC_NS(P_RC), .T_WC_NS(P_WC),
               .T_WP_NS(P_WP), .T_DS_NS(P_DS), .T_AA_NS(P_AA),
               .T_RECOVER_NS(P_REC)) uut (
        .clk(clk), .rst_n(rst_n), .retention_exit(retention_exit),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_din(mem_din), .mem_dout(mem_dout)
    );

    // Small RAM model indexed by the low address byte
    logic model [0:255];
    always @(negedge clk)
        if (!mem_ce_n && !mem_we_n) model[mem_addr[7:0]] <= mem_din;
    assign mem_dout = (!mem_ce_n && mem_we_n) ? model[mem_addr[7:0]] : 1'b0;

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    typedef struct packed { logic wr; logic [15:0] a; logic d; } vec_t;
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0000, 1'b1}, '{1'b1, 16'hFFFF, 1'b1}, '{1'b1, 16'h00A5, 1'b0},
        '{1'b1, 16'h125A, 1'b1}, '{1'b0, 16'h0000, 1'b1}, '{1'b0, 16'hFFFF, 1'b1},
        '{1'b0, 16'h00A5, 1'b0}, '{1'b1, 16'h0000, 1'b0}, '{1'b0, 16'h0000, 1'b0},
        '{1'b0, 16'h125A, 1'b1}
    };

    // Called at a negedge; returns at the negedge of the ack cycle.
    task automatic run_txn(input logic wr, input logic [15:0] a, input logic d,
                           output int lat, output int we_cnt, output int ce_cnt,
                           output int bad);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; we_cnt = 0; ce_cnt = 0; bad = 0;
        while (!ack) begin
            if (!mem_we_n) we_cnt++;
            if (!mem_ce_n) begin
                ce_cnt++;
                if (mem_addr != a || (wr && mem_din != d)) bad++;
            end
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #(CLK * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat, wec, cec, bad, n;
        logic prev_rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 R8: reset state
        check(mem_ce_n && mem_we_n, "R1 standby after reset", mem_ce_n, 1);
        check(!ack && !req_ready, "R8 no ready after reset", req_ready, 0);
        n = 0;
        while (!req_ready) begin
            check(mem_ce_n && mem_we_n, "R8 strobes high in recovery", mem_ce_n, 1);
            @(negedge clk); n++;
        end
        check(n == E_REC, "R8 recovery length", n, E_REC);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            prev_rd = rd_data;
            run_txn(VECS[i].wr, VECS[i].a, VECS[i].d, lat, wec, cec, bad);
            check(bad == 0, "R4 address/data stable", bad, 0);
            check(mem_ce_n && mem_we_n, "R1 standby at ack", mem_ce_n, 1);
            if (VECS[i].wr) begin
                check(lat == E_PULSE + 3, "R3 write latency", lat, E_PULSE + 3);
                check(wec == E_PULSE, "R3 write pulse width", wec, E_PULSE);
                check(rd_data == prev_rd, "R5 rd_data held over write", rd_data, prev_rd);
                check(req_ready, "R7 ready after write", req_ready, 1);
            end else begin
                check(lat == E_AA + 1, "R5 read latency", lat, E_AA + 1);
                check(cec == E_AA && wec == 0, "R5 read strobe window", cec, E_AA);
                check(rd_data == VECS[i].d, "R5 read data", rd_data, VECS[i].d);
                n = 0;
                #1;
                while (!req_ready) begin @(negedge clk); n++; #1; end
                check(n == E_RC - E_AA - 1, "R7 read cycle spacing", n, E_RC - E_AA - 1);
            end
            @(negedge clk);
            check(!ack, "R6 ack single cycle", ack, 0);
        end

        // R9: retention exit colliding with a pending read
        retention_exit = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'hFFFF;
        #1;
        check(!req_ready, "R9 ready dropped by retention exit", req_ready, 0);
        check(!req_ready, "R2 no acceptance during retention exit", req_ready, 0);
        @(negedge clk);
        retention_exit = 1'b0;
        n = 0;
        #1;
        while (!req_ready) begin
            if (!mem_ce_n) bad++;
            @(negedge clk); n++; #1;
        end
        check(n == E_REC, "R9 recovery after retention exit", n, E_REC);
        check(mem_ce_n, "R9 no access during recovery", mem_ce_n, 1);
        @(negedge clk);
        run_txn(1'b0, 16'hFFFF, 1'b0, lat, wec, cec, bad);
        check(rd_data == 1'b1 && lat == E_AA + 1, "R9 request served after recovery", rd_data, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule